// File: doc/BRIEF.md
# SPI Master Engine with Clean Shutdown

This block is a register-programmed SPI master. It shifts 8-bit frames, most significant bit first, on a serial clock that it divides down from the system clock. Software writes one word into a transmit holding register. The engine moves that word into its shift register, clocks it out on `mosi`, and samples `miso` at the same time. When the last bit has been taken, the received word lands in a receive register. Three status flags report the state of the engine: transmit buffer empty, receive register full, and busy. A receive-only mode runs frames back to back without any transmit data and holds `mosi` low.

The enable bit can be cleared at any time without tearing a frame. A frame that is already clocking finishes, and no further frame starts. A word that was waiting in the transmit buffer is dropped. In receive-only mode, a frame that has been loaded but has not yet produced its first clock edge is abandoned on the spot. Busy therefore always returns low after a disable, whatever the mode or buffer state.

Register map, with one address port shared by reads and writes:
- Address 0, control: bit 0 enable, bit 1 receive-only, bits 4:2 divider select `d`.
- Address 1: a write loads the transmit word; a read returns the receive word.
- Address 2, status: bit 0 TX-empty, bit 1 RX-full, bit 2 busy.

Top module: `spi_frame_master`

## Requirements
- R1: After reset, status reads 0x01 (TX-empty set, RX-full and busy clear), and `sck` and `mosi` are low.
- R2: A write to address 1 while enabled clears TX-empty (status bit 0). TX-empty sets again when the word moves into the shift register. At that moment busy (bit 2) is already high.
- R3: Frames are 8 bits, MSB first, in mode 0. `mosi` carries bit 7 before the first rising `sck`, changes only after falling edges, and holds steady while `sck` is high. `miso` is sampled on rising edges.
- R4: RX-full (status bit 1) sets only once the eighth bit has been sampled and the full word sits in the receive register. A read of address 1 clears it.
- R5: The `sck` period is 2^(d+1) system clocks, where d is control bits 4:2 (so 2 to 256). `sck` stays low whenever busy is low.
- R6: Busy is high from the load of a frame until its last falling `sck` edge. If the buffer is refilled before that edge, busy stays high without a gap between frames.
- R7: Clearing enable in the middle of a full-duplex frame lets that frame finish with correct data. Busy then falls, and no further `sck` edges occur while disabled.
- R8: A disable while a transmit word is pending discards that word. TX-empty reads 1, busy falls, and the word is never sent, even after re-enabling. A write to address 1 while disabled is ignored.
- R9: With control bit 1 set, frames run continuously while enabled with no transmit write. `mosi` stays low, and each frame delivers the `miso` word.
- R10: In receive-only mode, a disable that arrives after RX-full rose but before the next frame's first `sck` edge drops busy within two cycles, with no further `sck` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register address for reads and writes |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe (a read of address 1 clears RX-full) |
| rdData | output | 8 | Read data for `addr`, combinational |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Wrong internal state shows up at the ports in a few characteristic ways.
- A stuck busy flag shows as status bit 2 still set a few cycles after a disable, long before any later frame could explain it. The receive-only abort window gives a bad sequencer only eight system clocks before the next `sck` edge gives it away.
- A miscounted bit index or a mis-timed sample shows one frame later as a shifted word in the receive register or in the captured `mosi` pattern.
- A pending word that was not discarded appears as fresh `sck` edges within a few cycles of re-enabling.
- A divider error changes the measured spacing between rising `sck` edges at once.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

  typedef struct packed {
    logic load;      // move a frame into the shift register
    logic loadZero;  // receive-only frame: shift zeros out
    logic rise;      // rising sck edge this cycle
    logic fall;      // falling sck edge this cycle
    logic capture;   // last falling edge: store received word
  } frameStrobes_t;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_DATA   = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;

endpackage

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_frame_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DIV_SEL_W = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrCtrl,
  input  logic [DIV_SEL_W+1:0]   ctrlBits,
  input  logic                   txFull,
  output frameStrobes_t          strobe,
  output logic                   busy,
  output logic                   sck,
  output logic                   enable,
  output logic                   rxOnly,
  output logic [DIV_SEL_W-1:0]   divSel
);

  localparam int CNT_W = (1 << DIV_SEL_W) - 1;
  localparam int BIT_W = $clog2(DATA_W);

  logic [CNT_W-1:0] halfCnt;
  logic [CNT_W-1:0] halfLimit;
  logic [BIT_W-1:0] bitCnt;
  logic             frameRxOnly;
  logic             tick;
  logic             lastFall;
  logic             canStart;
  logic             abortFrame;

  always_comb begin
    halfLimit  = CNT_W'((32'd1 << divSel) - 32'd1);
    tick       = (halfCnt == halfLimit);
    canStart   = enable && (rxOnly || txFull);
    lastFall   = busy && tick && sck && (bitCnt == BIT_W'(DATA_W - 1));
    // receive-only frame loaded but not yet clocked: drop it on disable
    abortFrame = busy && !enable && frameRxOnly && !sck && (bitCnt == '0);
    strobe.load     = (!busy || lastFall) && canStart;
    strobe.loadZero = rxOnly;
    strobe.rise     = busy && tick && !sck && !abortFrame;
    strobe.fall     = busy && tick && sck;
    strobe.capture  = lastFall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable <= 1'b0;
      rxOnly <= 1'b0;
      divSel <= '0;
    end else if (wrCtrl) begin
      enable <= ctrlBits[0];
      rxOnly <= ctrlBits[1];
      divSel <= ctrlBits[DIV_SEL_W+1:2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy        <= 1'b0;
      sck         <= 1'b0;
      bitCnt      <= '0;
      halfCnt     <= '0;
      frameRxOnly <= 1'b0;
    end else begin
      if (abortFrame)        busy <= 1'b0;
      else if (strobe.load)  busy <= 1'b1;
      else if (lastFall)     busy <= 1'b0;

      if (strobe.rise)       sck <= 1'b1;
      else if (strobe.fall)  sck <= 1'b0;

      if (strobe.load || !busy || tick) halfCnt <= '0;
      else                              halfCnt <= halfCnt + 1'b1;

      if (strobe.load)       bitCnt <= '0;
      else if (strobe.fall)  bitCnt <= bitCnt + 1'b1;

      if (strobe.load)       frameRxOnly <= rxOnly;
    end
  end

  // R5: no clock activity outside a frame
  p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sck);

  // R7: nothing starts while disabled
  p_no_start_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !busy) |=> !busy);

  // R10: an unclocked receive-only frame is dropped on disable
  p_abort_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !enable && frameRxOnly && !sck && bitCnt == '0) |=> (!busy && !sck));

endmodule

// File: rtl/spi_frame_dp.sv
module spi_frame_dp
  import spi_frame_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  frameStrobes_t     strobe,
  input  logic              enable,
  input  logic              wrTx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdRx,
  input  logic              miso,
  output logic              txFull,
  output logic              rxFull,
  output logic [DATA_W-1:0] rxWord,
  output logic              txBit
);

  logic [DATA_W-1:0] txBuf;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-2:0] rxShift;
  logic              rxBit;

  assign txBit = txShift[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf   <= '0;
      txFull  <= 1'b0;
      txShift <= '0;
      rxShift <= '0;
      rxBit   <= 1'b0;
      rxWord  <= '0;
      rxFull  <= 1'b0;
    end else begin
      if (!enable)           txFull <= 1'b0;
      else if (wrTx)         txFull <= 1'b1;
      else if (strobe.load)  txFull <= 1'b0;

      if (enable && wrTx)    txBuf <= wrData;

      if (strobe.load)       txShift <= strobe.loadZero ? '0 : txBuf;
      else if (strobe.fall)  txShift <= {txShift[DATA_W-2:0], 1'b0};

      if (strobe.rise)       rxBit <= miso;
      if (strobe.fall)       rxShift <= {rxShift[DATA_W-3:0], rxBit};

      if (strobe.capture) begin
        rxWord <= {rxShift, rxBit};
        rxFull <= 1'b1;
      end else if (rdRx) begin
        rxFull <= 1'b0;
      end
    end
  end

  // R8: a disabled engine never holds a pending word
  p_pending_dropped_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !txFull);

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spi_frame_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DIV_SEL_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);

  frameStrobes_t          strobe;
  logic                   busy;
  logic                   enable;
  logic                   rxOnly;
  logic [DIV_SEL_W-1:0]   divSel;
  logic                   txFull;
  logic                   rxFull;
  logic [DATA_W-1:0]      rxWord;
  logic                   txBit;
  logic                   wrCtrl;
  logic                   wrTx;
  logic                   rdRx;

  assign wrCtrl = wrEn && (addr == ADDR_CTRL);
  assign wrTx   = wrEn && (addr == ADDR_DATA);
  assign rdRx   = rdEn && (addr == ADDR_DATA);
  assign mosi   = busy && txBit;

  always_comb begin
    case (addr)
      ADDR_CTRL:   rdData = DATA_W'({divSel, rxOnly, enable});
      ADDR_DATA:   rdData = rxWord;
      ADDR_STATUS: rdData = DATA_W'({busy, rxFull, !txFull});
      default:     rdData = '0;
    endcase
  end

  spi_frame_ctrl #(.DATA_W(DATA_W), .DIV_SEL_W(DIV_SEL_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrCtrl   (wrCtrl),
    .ctrlBits (wrData[DIV_SEL_W+1:0]),
    .txFull   (txFull),
    .strobe   (strobe),
    .busy     (busy),
    .sck      (sck),
    .enable   (enable),
    .rxOnly   (rxOnly),
    .divSel   (divSel)
  );

  spi_frame_dp #(.DATA_W(DATA_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .enable (enable),
    .wrTx   (wrTx),
    .wrData (wrData),
    .rdRx   (rdRx),
    .miso   (miso),
    .txFull (txFull),
    .rxFull (rxFull),
    .rxWord (rxWord),
    .txBit  (txBit)
  );

  // R3: data out holds while the clock is high
  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi));

  // R4: a received word appears only on a falling clock edge
  p_rx_on_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> ($past(sck) && !sck));

  // R2: buffer empties by loading, and then busy is high
  p_txe_means_loaded_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(txFull) && enable) |-> busy);

endmodule

// File: tb/spi_frame_master_test.sv
`timescale 1ns/1ps
module spi_frame_master_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       sck;
  logic       mosi;
  logic       miso;

  int checks = 0;
  int fails = 0;

  // slave model
  logic [7:0] slaveWord = 8'h00;
  int         fallBase = 0;
  int         fallCount = 0;
  int         riseCount = 0;
  logic [7:0] mosiCap = 8'h00;

  always #2.5 clk = ~clk;

  spi_frame_master uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .sck(sck), .mosi(mosi), .miso(miso)
  );

  assign miso = slaveWord[7 - ((fallCount - fallBase) & 7)];

  always @(negedge sck) fallCount <= fallCount + 1;
  always @(posedge sck) begin
    riseCount <= riseCount + 1;
    mosiCap   <= {mosiCap[6:0], mosi};
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic peek(output logic [7:0] st);
    addr = 2'd2;
    rdEn = 1'b0;
    #1;
    st = rdData;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitStatus(input int idx, input logic val, input int limit);
    logic [7:0] st;
    for (int i = 0; i < limit; i++) begin
      peek(st);
      if (st[idx] == val) return;
      @(negedge clk);
    end
  endtask

  task automatic startSlave(input logic [7:0] w);
    slaveWord = w;
    fallBase  = fallCount;
  endtask

  task automatic t_reset();
    logic [7:0] st;
    @(negedge clk);
    peek(st);
    check(st == 8'h01, "R1", "status after reset", st, 8'h01);
    check(!sck && !mosi, "R1", "sck/mosi after reset", {sck, mosi}, 0);
  endtask

  task automatic t_fullDuplex();
    logic [7:0] st, d;
    regWrite(2'd0, 8'h01);
    startSlave(8'h3C);
    regWrite(2'd1, 8'hA5);
    peek(st);
    check(st[0] == 1'b0, "R2", "TX-empty after write", st[0], 0);
    @(negedge clk);
    peek(st);
    check(st[0] == 1'b1 && st[2] == 1'b1, "R2", "TX-empty+busy at load", st, 8'h05);
    check(st[1] == 1'b0, "R4", "RX-full before frame end", st[1], 0);
    waitStatus(1, 1'b1, 100);
    peek(st);
    check(st[1] == 1'b1, "R4", "RX-full after frame", st[1], 1);
    check(st[2] == 1'b0, "R6", "busy after last edge", st[2], 0);
    check(mosiCap == 8'hA5, "R3", "mosi pattern", mosiCap, 8'hA5);
    regRead(2'd1, d);
    check(d == 8'h3C, "R3", "received word", d, 8'h3C);
    peek(st);
    check(st[1] == 1'b0, "R4", "RX-full after read", st[1], 0);
  endtask

  task automatic t_divider();
    logic [7:0] d;
    int n;
    logic prev;
    regWrite(2'd0, 8'h0D);
    startSlave(8'h00);
    regWrite(2'd1, 8'h81);
    for (int i = 0; i < 100 && !sck; i++) @(negedge clk);
    prev = 1'b1;
    n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      n++;
      if (sck && !prev) break;
      prev = sck;
    end
    check(n == 16, "R5", "sck period d=3", n, 16);
    waitStatus(1, 1'b1, 300);
    check(mosiCap == 8'h81, "R5", "mosi pattern at d=3", mosiCap, 8'h81);
    regRead(2'd1, d);
  endtask

  task automatic t_backToBack();
    logic [7:0] st, d;
    int base, lowSeen;
    regWrite(2'd0, 8'h01);
    startSlave(8'h5A);
    base = riseCount;
    regWrite(2'd1, 8'h11);
    @(negedge clk);
    regWrite(2'd1, 8'h22);
    lowSeen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      peek(st);
      if ((riseCount - base) >= 16 && !st[2]) break;
      if (!st[2]) lowSeen++;
    end
    check(lowSeen == 0, "R6", "busy gaps between frames", lowSeen, 0);
    check(mosiCap == 8'h22, "R6", "second frame mosi", mosiCap, 8'h22);
    regRead(2'd1, d);
    check(d == 8'h5A, "R6", "second frame rx", d, 8'h5A);
  endtask

  task automatic t_disableMid();
    logic [7:0] st, d;
    int base;
    regWrite(2'd0, 8'h01);
    startSlave(8'h96);
    regWrite(2'd1, 8'hC3);
    regWrite(2'd0, 8'h00);
    waitStatus(2, 1'b0, 100);
    peek(st);
    check(st[1] == 1'b1, "R7", "frame completed after disable", st[1], 1);
    check(mosiCap == 8'hC3, "R7", "mosi of finished frame", mosiCap, 8'hC3);
    regRead(2'd1, d);
    check(d == 8'h96, "R7", "rx of finished frame", d, 8'h96);
    base = riseCount;
    repeat (30) @(negedge clk);
    peek(st);
    check(riseCount == base && !st[2], "R7", "edges while disabled",
          riseCount - base, 0);
  endtask

  task automatic t_disablePending();
    logic [7:0] st, d;
    int base;
    regWrite(2'd0, 8'h05);
    startSlave(8'h00);
    regWrite(2'd1, 8'h0F);
    waitStatus(0, 1'b1, 20);
    regWrite(2'd1, 8'hF0);
    peek(st);
    check(st[0] == 1'b0, "R8", "word pending", st[0], 0);
    regWrite(2'd0, 8'h00);
    waitStatus(2, 1'b0, 100);
    peek(st);
    check(st[0] == 1'b1 && st[2] == 1'b0, "R8", "status after disable", st, 8'h03);
    check(mosiCap == 8'h0F, "R8", "only first word sent", mosiCap, 8'h0F);
    base = riseCount;
    repeat (40) @(negedge clk);
    check(riseCount == base, "R8", "pending word not sent", riseCount - base, 0);
    regWrite(2'd0, 8'h01);
    repeat (20) @(negedge clk);
    peek(st);
    check(st[2] == 1'b0 && riseCount == base, "R8", "busy after re-enable", st[2], 0);
    regWrite(2'd0, 8'h00);
    regWrite(2'd1, 8'h77);
    peek(st);
    check(st[0] == 1'b1, "R8", "write while disabled ignored", st[0], 1);
    regWrite(2'd0, 8'h01);
    repeat (10) @(negedge clk);
    peek(st);
    check(st[2] == 1'b0, "R8", "no frame from ignored write", st[2], 0);
    regWrite(2'd0, 8'h00);
    regRead(2'd1, d);
  endtask

  task automatic t_rxOnly();
    logic [7:0] st, d;
    int bad;
    startSlave(8'hE7);
    regWrite(2'd0, 8'h0F);
    bad = 0;
    for (int i = 0; i < 400; i++) begin
      peek(st);
      if (mosi) bad++;
      if (st[1]) break;
      @(negedge clk);
    end
    check(bad == 0, "R9", "mosi high in receive-only", bad, 0);
    regRead(2'd1, d);
    check(d == 8'hE7, "R9", "receive-only word", d, 8'hE7);
    peek(st);
    check(st[2] == 1'b1, "R9", "continuous busy", st[2], 1);
  endtask

  task automatic t_rxAbort();
    logic [7:0] st;
    int base;
    waitStatus(1, 1'b1, 400);
    regWrite(2'd0, 8'h0C);
    @(negedge clk);
    peek(st);
    check(st[2] == 1'b0, "R10", "busy after receive-only disable", st[2], 0);
    base = riseCount;
    repeat (40) @(negedge clk);
    peek(st);
    check(riseCount == base && !sck && !st[2], "R10", "sck stopped",
          riseCount - base, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_fullDuplex();
    t_divider();
    t_backToBack();
    t_disableMid();
    t_disablePending();
    t_rxOnly();
    t_rxAbort();
    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule